// File: doc/BRIEF.md
# Overload Guard Sequencer

This block decides whether a supply output may stay enabled while overload and overtemperature detectors are active. When an overload is reported with pulsed limiting selected, the output keeps running for an on window and is then switched off for a fixed off window. This on/off cycle repeats until a whole on window passes with no overload. With static limiting selected, the output stays on, the external clamp limits the current, and the block only reports the event. An overtemperature report overrides everything else and forces the output off until the condition ends.

Each recovery path can end in one of two ways. In the automatic case the output simply comes back. In the latched case the block sends a one-cycle request to clear the voltage-select field. With that field at zero the output stays off until software writes a new level. All durations are counted in pulses of a slow tick input, and the window lengths are parameters. Every control pin is a plain level or pulse; there is no data stream at this boundary.

Top module: `overload_guard`

## Requirements
- R1: After reset, `out_en` is 1 and `vsel_clear`, `ovl_evt` and `ovt_evt` are all 0.
- R2: Pulsed mode is selected by `cfg_static`=0. In that mode, an overload sampled while running starts an on window. During the window `out_en` stays 1 for ON_SHORT_TICKS tick pulses when `cfg_long_on`=0, or for ON_LONG_TICKS tick pulses when `cfg_long_on`=1.
- R3: An on window in which an overload was seen is followed by an off window. In the off window `out_en` is 0 from the final tick of the on window until the OFF_TICKS-th tick that follows, and then a new on window begins.
- R4: An on window with no overload sampled during it returns the block to running. `ovl_evt` is a single-cycle pulse, one cycle after an overload starts an episode, and it does not pulse again within that episode.
- R5: Static mode is selected by `cfg_static`=1. In that mode an overload never drops `out_en`, whatever ticks arrive, but it still produces the `ovl_evt` pulse.
- R6: When an overload episode ends, `vsel_clear` pulses for exactly one cycle if `cfg_ovl_latch`=1, and stays 0 if `cfg_ovl_latch`=0. In both cases `out_en` is 1 afterwards.
- R7: An overtemperature sampled in any state drives `out_en` to 0 in the next cycle and holds it at 0 while the condition remains. `ovt_evt` pulses once on entry.
- R8: When the overtemperature clears, `out_en` returns to 1 in the next cycle. `vsel_clear` pulses once if `cfg_ovt_latch`=1 and stays 0 if `cfg_ovt_latch`=0.
- R9: Setting `cfg_static`=1 during an on or off window moves the block to static clamping, so `out_en` is 1 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle pulse of the slow timebase |
| ovl_det | input | 1 | Overload detected |
| ovt_det | input | 1 | Overtemperature detected |
| cfg_static | input | 1 | 1 = static clamp, 0 = pulsed on/off retry |
| cfg_long_on | input | 1 | 1 = long on window, 0 = short on window |
| cfg_ovl_latch | input | 1 | 1 = request a voltage-select clear when an overload ends |
| cfg_ovt_latch | input | 1 | 1 = request a voltage-select clear when an overtemperature ends |
| out_en | output | 1 | Output stage enable |
| vsel_clear | output | 1 | One-cycle request to zero the voltage-select field |
| ovl_evt | output | 1 | One-cycle overload event for the status latch |
| ovt_evt | output | 1 | One-cycle overtemperature event for the status latch |

## Verification
A corrupted state register appears at `out_en` within one cycle, because the enable is decoded straight from that register. A window counter that runs fast or slow moves the falling or rising edge of `out_en` by whole ticks, so the bench checks the level after every single tick. A lost "overload seen" flag makes a clean window turn into an off window, or the reverse, and this shows as a wrong `out_en` level on the last tick of the window. A bad recovery decision shows as a missing or extra `vsel_clear` pulse in the cycle the episode ends.

// File: rtl/ovg_pkg.sv
package ovg_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ON    = 3'd1,
    ST_OFF   = 3'd2,
    ST_CLAMP = 3'd3,
    ST_HOT   = 3'd4
  } ovg_state_e;
endpackage

// File: rtl/ovg_tick_timer.sv
module ovg_tick_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  // Window ends on the tick that brings the count to the limit.
  assign done = tick && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ovg_ctrl.sv
module ovg_ctrl
  import ovg_pkg::*;
#(
  parameter int CW             = 10,
  parameter int ON_SHORT_TICKS = 90,
  parameter int ON_LONG_TICKS  = 180,
  parameter int OFF_TICKS      = 900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovl_det,
  input  logic          ovt_det,
  input  logic          cfg_static,
  input  logic          cfg_long_on,
  input  logic          cfg_ovl_latch,
  input  logic          cfg_ovt_latch,
  input  logic          done,
  output logic          restart,
  output logic [CW-1:0] limit,
  output logic          out_en,
  output logic          vsel_clear,
  output logic          ovl_evt,
  output logic          ovt_evt
);
  ovg_state_e state_q, state_n;
  logic seen_q, seen_n;
  logic clr_n, ovl_evt_n, ovt_evt_n;

  always_comb begin
    if (state_q == ST_OFF)  limit = CW'(OFF_TICKS);
    else if (cfg_long_on)   limit = CW'(ON_LONG_TICKS);
    else                    limit = CW'(ON_SHORT_TICKS);
  end

  always_comb begin
    state_n   = state_q;
    seen_n    = seen_q;
    clr_n     = 1'b0;
    ovl_evt_n = 1'b0;
    ovt_evt_n = 1'b0;
    if (ovt_det) begin
      // Thermal shutdown overrides every other state.
      state_n   = ST_HOT;
      ovt_evt_n = (state_q != ST_HOT);
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (ovl_det) begin
            state_n   = cfg_static ? ST_CLAMP : ST_ON;
            seen_n    = 1'b1;
            ovl_evt_n = 1'b1;
          end
        end
        ST_ON: begin
          seen_n = seen_q | ovl_det;
          if (cfg_static) begin
            state_n = ST_CLAMP;
          end else if (done) begin
            if (seen_q || ovl_det) begin
              state_n = ST_OFF;
            end else begin
              state_n = ST_RUN;
              clr_n   = cfg_ovl_latch;
            end
          end
        end
        ST_OFF: begin
          if (cfg_static) begin
            state_n = ST_CLAMP;
          end else if (done) begin
            state_n = ST_ON;
            seen_n  = 1'b0;
          end
        end
        ST_CLAMP: begin
          if (!ovl_det) begin
            state_n = ST_RUN;
            clr_n   = cfg_ovl_latch;
          end
        end
        ST_HOT: begin
          state_n = ST_RUN;
          clr_n   = cfg_ovt_latch;
        end
        default: state_n = ST_RUN;
      endcase
    end
  end

  assign restart = (state_n != state_q);
  assign out_en  = (state_q != ST_OFF) && (state_q != ST_HOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      seen_q     <= 1'b0;
      vsel_clear <= 1'b0;
      ovl_evt    <= 1'b0;
      ovt_evt    <= 1'b0;
    end else begin
      state_q    <= state_n;
      seen_q     <= seen_n;
      vsel_clear <= clr_n;
      ovl_evt    <= ovl_evt_n;
      ovt_evt    <= ovt_evt_n;
    end
  end
endmodule

// File: rtl/overload_guard.sv
module overload_guard #(
  parameter int ON_SHORT_TICKS = 90,
  parameter int ON_LONG_TICKS  = 180,
  parameter int OFF_TICKS      = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ovl_det,
  input  logic ovt_det,
  input  logic cfg_static,
  input  logic cfg_long_on,
  input  logic cfg_ovl_latch,
  input  logic cfg_ovt_latch,
  output logic out_en,
  output logic vsel_clear,
  output logic ovl_evt,
  output logic ovt_evt
);
  localparam int MAX_ON = (ON_LONG_TICKS > ON_SHORT_TICKS) ? ON_LONG_TICKS : ON_SHORT_TICKS;
  localparam int MAX_T  = (OFF_TICKS > MAX_ON) ? OFF_TICKS : MAX_ON;
  localparam int CW     = $clog2(MAX_T + 1);

  logic          restart, done;
  logic [CW-1:0] limit;

  ovg_tick_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .limit(limit), .done(done)
  );

  ovg_ctrl #(
    .CW(CW), .ON_SHORT_TICKS(ON_SHORT_TICKS),
    .ON_LONG_TICKS(ON_LONG_TICKS), .OFF_TICKS(OFF_TICKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ovl_det(ovl_det), .ovt_det(ovt_det),
    .cfg_static(cfg_static), .cfg_long_on(cfg_long_on),
    .cfg_ovl_latch(cfg_ovl_latch), .cfg_ovt_latch(cfg_ovt_latch),
    .done(done), .restart(restart), .limit(limit), .out_en(out_en),
    .vsel_clear(vsel_clear), .ovl_evt(ovl_evt), .ovt_evt(ovt_evt)
  );
endmodule

// File: rtl/ovg_checker.sv
module ovg_checker (
  input logic clk,
  input logic rst_n,
  input logic ovt_det,
  input logic cfg_static,
  input logic out_en,
  input logic vsel_clear,
  input logic ovl_evt,
  input logic ovt_evt
);
  AST_HOT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ovt_det |=> !out_en); // R7
  AST_HOT_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovt_evt |=> !ovt_evt); // R7
  AST_STATIC_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_static && !ovt_det && out_en) |=> out_en); // R5
  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vsel_clear |=> !vsel_clear); // R6
  AST_CLEAR_WITH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    vsel_clear |-> out_en); // R8
  AST_OVL_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_evt |=> !ovl_evt); // R4
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovl_evt && ovt_evt)); // R7
endmodule

bind overload_guard ovg_checker u_ovg_checker (
  .clk(clk), .rst_n(rst_n), .ovt_det(ovt_det), .cfg_static(cfg_static),
  .out_en(out_en), .vsel_clear(vsel_clear), .ovl_evt(ovl_evt), .ovt_evt(ovt_evt)
);

// File: tb/overload_guard_test.sv
`timescale 1ns/1ps
module overload_guard_test;
  localparam int SHORT_T = 3;
  localparam int LONG_T  = 5;
  localparam int OFF_T   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ovl_det = 1'b0, ovt_det = 1'b0;
  logic cfg_static = 1'b0, cfg_long_on = 1'b0, cfg_ovl_latch = 1'b0, cfg_ovt_latch = 1'b0;
  logic out_en, vsel_clear, ovl_evt, ovt_evt;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  overload_guard #(.ON_SHORT_TICKS(SHORT_T), .ON_LONG_TICKS(LONG_T), .OFF_TICKS(OFF_T)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ovl_det(ovl_det), .ovt_det(ovt_det),
    .cfg_static(cfg_static), .cfg_long_on(cfg_long_on), .cfg_ovl_latch(cfg_ovl_latch),
    .cfg_ovt_latch(cfg_ovt_latch), .out_en(out_en), .vsel_clear(vsel_clear),
    .ovl_evt(ovl_evt), .ovt_evt(ovt_evt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change and outputs are sampled 2 ns after a rising edge.
  task automatic cyc;
    @(posedge clk);
    #2;
  endtask

  task automatic tick1;
    tick = 1'b1;
    cyc();
    tick = 1'b0;
  endtask

  task automatic settle;
    ovl_det = 0; ovt_det = 0; cfg_static = 0;
    cyc(); cyc();
  endtask

  // Enter the off window of a pulsed sequence (short on window).
  task automatic go_off;
    cfg_long_on = 0;
    ovl_det = 1; cyc();
    for (int t = 0; t < SHORT_T; t++) tick1();
    ovl_det = 0;
    chk("R3 off window entered", out_en, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 out_en", out_en, 1'b1);
    chk("R1 vsel_clear", vsel_clear, 1'b0);
    chk("R1 ovl_evt", ovl_evt, 1'b0);
    chk("R1 ovt_evt", ovt_evt, 1'b0);

    // Pulsed sweep: window length x recovery policy x flagged-window count.
    for (int lng = 0; lng < 2; lng++)
      for (int lat = 0; lat < 2; lat++)
        for (int e = 1; e <= 3; e++) begin
          int n_on;
          settle();
          cfg_long_on = lng[0]; cfg_ovl_latch = lat[0];
          n_on = lng ? LONG_T : SHORT_T;
          ovl_det = 1; cyc();
          chk("R4 ovl_evt at episode start", ovl_evt, 1'b1);
          chk("R2 on at start", out_en, 1'b1);
          for (int w = 1; w <= e; w++) begin
            for (int t = 1; t <= n_on; t++) begin
              tick1();
              chk("R2 on window level", out_en, (t < n_on));
              chk("R4 no repeat ovl_evt", ovl_evt, 1'b0);
            end
            if (w == e) ovl_det = 0;
            for (int t = 1; t <= OFF_T; t++) begin
              tick1();
              chk("R3 off window level", out_en, (t == OFF_T));
            end
          end
          for (int t = 1; t <= n_on; t++) begin
            tick1();
            chk("R4 clean window stays on", out_en, 1'b1);
            chk("R6 clear on recovery", vsel_clear, (t == n_on) && lat[0]);
          end
          cyc();
          chk("R6 clear single cycle", vsel_clear, 1'b0);
          for (int t = 0; t < OFF_T + LONG_T; t++) begin
            tick1();
            chk("R4 back to running", out_en, 1'b1);
          end
        end

    // Brief overload in the middle of a retry window still flags it.
    settle(); cfg_ovl_latch = 0;
    go_off();
    for (int t = 0; t < OFF_T; t++) tick1();
    tick1(); ovl_det = 1; cyc(); ovl_det = 0;
    for (int t = 2; t <= SHORT_T; t++) tick1();
    chk("R3 mid-window overload forces off", out_en, 1'b0);
    for (int t = 0; t < OFF_T; t++) tick1();
    for (int t = 0; t < SHORT_T; t++) tick1();
    chk("R4 recovered after clean window", out_en, 1'b1);

    // Static clamp mode.
    for (int lat = 0; lat < 2; lat++) begin
      settle(); cfg_static = 1; cfg_ovl_latch = lat[0];
      ovl_det = 1; cyc();
      chk("R5 ovl_evt in static", ovl_evt, 1'b1);
      for (int t = 0; t < 3 * (LONG_T + OFF_T); t++) begin
        tick1();
        chk("R5 static never drops", out_en, 1'b1);
      end
      ovl_det = 0; cyc();
      chk("R6 static recovery clear", vsel_clear, lat[0]);
      chk("R6 static recovery enable", out_en, 1'b1);
    end

    // Switch to static during the off window.
    settle(); cfg_ovl_latch = 0;
    go_off();
    ovl_det = 1; cfg_static = 1; cyc();
    chk("R9 switch to clamp", out_en, 1'b1);
    tick1(); tick1();
    chk("R9 clamp holds", out_en, 1'b1);
    ovl_det = 0; cyc();
    chk("R9 clamp exit no clear", vsel_clear, 1'b0);

    // Overtemperature from each state: 0 run, 1 on, 2 off, 3 clamp.
    for (int lat = 0; lat < 2; lat++)
      for (int s = 0; s < 4; s++) begin
        settle(); cfg_ovt_latch = lat[0]; cfg_ovl_latch = 0;
        if (s == 1) begin ovl_det = 1; cyc(); end
        if (s == 2) go_off();
        if (s == 3) begin cfg_static = 1; ovl_det = 1; cyc(); end
        ovt_det = 1; cyc();
        chk("R7 forced off", out_en, 1'b0);
        chk("R7 ovt_evt", ovt_evt, 1'b1);
        ovl_det = 0; cfg_static = 0;
        for (int t = 0; t < OFF_T + 2; t++) begin
          tick1();
          chk("R7 held off", out_en, 1'b0);
          chk("R7 ovt_evt once", ovt_evt, 1'b0);
        end
        ovt_det = 0; cyc();
        chk("R8 re-enabled", out_en, 1'b1);
        chk("R8 clear policy", vsel_clear, lat[0]);
        cyc();
        chk("R8 clear single", vsel_clear, 1'b0);
      end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule